// File: doc/BRIEF.md
# Control Response Rate Selector

This block chooses the transmit rate for a short control reply (an acknowledgement or a clear-to-send) sent back to a received frame. The receive path gives it the rate code of the frame that prompted the reply. Two 16-bit rate tables, a preferred set and a required set, come from configuration registers. A one-cycle request strobe starts a lookup. One clock later the block presents a registered rate code, a one-cycle valid pulse and a flag that shows when no table entry could be used.

A rate code is the bit position of that rate in the tables. Codes 0 to 3 are the 1, 2, 5.5 and 11 Mb/s DSSS/CCK rates. Codes 8 to 15 are the OFDM rates from 6 up to 54 Mb/s. Codes 4 to 7 name no rate. The block compares rates by their real speed and not by bit position. The search looks at the preferred table first. It uses the required table only when the preferred table has no usable entry. The reply rate never exceeds the rate of the incoming frame.

Top module: `rsp_rate_sel`

## Requirements
- R1: Table bits 0, 1, 2 and 3 (and rate codes 0 to 3) stand for 1, 2, 5.5 and 11 Mb/s.
- R2: Table bits 8 to 15 (and rate codes 8 to 15) stand for 6, 9, 12, 18, 24, 36, 48 and 54 Mb/s, in ascending order.
- R3: Rates are ordered by actual speed. For example, 6 Mb/s (code 8) ranks below 11 Mb/s (code 3), so an 11 Mb/s frame can be answered at 6 Mb/s.
- R4: The result is the fastest rate set in the preferred table whose speed does not exceed the incoming rate.
- R5: The required table is searched with the same rule only when no preferred-table entry qualifies. When a preferred entry qualifies, the required table has no effect.
- R6: When neither table has a qualifying entry, the result is code 0 (1 Mb/s) and the fallback flag is 1. Otherwise the fallback flag is 0.
- R7: Bits 4 to 7 of both tables are ignored.
- R8: A request sampled at a clock edge produces rsp_valid high in the following cycle for exactly that cycle. Without a request, rsp_valid is 0 and rsp_rate and rsp_fallback keep their values.
- R9: An incoming rate code from 4 to 7 matches no rate, so the result is the fallback.
- R10: While rst is high, rsp_valid, rsp_rate and rsp_fallback are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Lookup request strobe |
| rx_rate | input | 4 | Rate code of the received frame |
| basic_tbl | input | 16 | Preferred rate table |
| mand_tbl | input | 16 | Required rate table |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_rate | output | 4 | Chosen reply rate code |
| rsp_fallback | output | 1 | No table entry qualified |

## Verification
Every lookup takes a single registered step, so any fault in the eligibility mask, the rank order or the choice between tables shows up on rsp_rate or rsp_fallback in the cycle right after the request. A rank table that follows bit position rather than speed can only be seen through cross-family cases, such as 11 Mb/s against 6 or 9 Mb/s entries, so those cases are driven on purpose. A stuck or stretched valid register shows up as a wrong rsp_valid level in the cycle after a request, or in the cycle after a cycle with no request.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
    localparam int RATE_BITS = 16;
    localparam int CODE_W    = $clog2(RATE_BITS);
    localparam int NUM_RANK  = 12;
    localparam int RANK_W    = $clog2(NUM_RANK);

    typedef logic [CODE_W-1:0]    rate_code_t;
    typedef logic [RATE_BITS-1:0] rate_map_t;

    // table bits that carry a rate; 4..7 are dead
    localparam rate_map_t USED_MASK = 16'hFF0F;

    typedef struct packed {
        logic              ok;
        logic [RANK_W-1:0] rank;
    } rank_t;

    typedef struct packed {
        logic       fallback;
        rate_code_t code;
    } resp_t;

    // speed rank of a code: 1,2,5.5,6,9,11,12,18,24,36,48,54
    function automatic rank_t code_rank(rate_code_t c);
        rank_t r;
        r.ok = 1'b1;
        case (c)
            4'd0:    r.rank = 4'd0;
            4'd1:    r.rank = 4'd1;
            4'd2:    r.rank = 4'd2;
            4'd8:    r.rank = 4'd3;
            4'd9:    r.rank = 4'd4;
            4'd3:    r.rank = 4'd5;
            4'd10:   r.rank = 4'd6;
            4'd11:   r.rank = 4'd7;
            4'd12:   r.rank = 4'd8;
            4'd13:   r.rank = 4'd9;
            4'd14:   r.rank = 4'd10;
            4'd15:   r.rank = 4'd11;
            default: begin r.ok = 1'b0; r.rank = '0; end
        endcase
        return r;
    endfunction

    function automatic rate_code_t rank_code(int r);
        case (r)
            0:       return 4'd0;
            1:       return 4'd1;
            2:       return 4'd2;
            3:       return 4'd8;
            4:       return 4'd9;
            5:       return 4'd3;
            6:       return 4'd10;
            7:       return 4'd11;
            8:       return 4'd12;
            9:       return 4'd13;
            10:      return 4'd14;
            default: return 4'd15;
        endcase
    endfunction
endpackage

// File: rtl/rsel_elig.sv
module rsel_elig
    import rsel_pkg::*;
(
    input  rate_code_t in_code,
    output rate_map_t  elig
);
    rank_t lim;
    rank_t rk;

    always_comb begin
        lim  = code_rank(in_code);
        elig = '0;
        rk   = '0;
        for (int g = 0; g < RATE_BITS; g++) begin
            rk = code_rank(rate_code_t'(g));
            elig[g] = lim.ok && rk.ok && (rk.rank <= lim.rank);
        end
    end
endmodule

// File: rtl/rsel_pick.sv
module rsel_pick
    import rsel_pkg::*;
(
    input  rate_map_t  cand,
    output logic       found,
    output rate_code_t code
);
    // ascending walk: the last hit is the fastest
    always_comb begin
        found = 1'b0;
        code  = '0;
        for (int r = 0; r < NUM_RANK; r++) begin
            if (cand[rank_code(r)]) begin
                found = 1'b1;
                code  = rank_code(r);
            end
        end
    end
endmodule

// File: rtl/rsp_rate_sel.sv
module rsp_rate_sel
    import rsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic [3:0]  rx_rate,
    input  logic [15:0] basic_tbl,
    input  logic [15:0] mand_tbl,
    output logic        rsp_valid,
    output logic [3:0]  rsp_rate,
    output logic        rsp_fallback
);
    localparam int NSTAGE = 2;

    rate_map_t  elig;
    rate_map_t  tbl   [NSTAGE];
    logic       hit   [NSTAGE];
    rate_code_t hcode [NSTAGE];
    resp_t      nxt;
    resp_t      cur;
    logic       vld;

    assign tbl[0] = basic_tbl & USED_MASK;
    assign tbl[1] = mand_tbl  & USED_MASK;

    rsel_elig u_elig (
        .in_code (rx_rate),
        .elig    (elig)
    );

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        rsel_pick u_pick (
            .cand  (tbl[s] & elig),
            .found (hit[s]),
            .code  (hcode[s])
        );
    end

    always_comb begin
        if (hit[0])      nxt = '{fallback: 1'b0, code: hcode[0]};
        else if (hit[1]) nxt = '{fallback: 1'b0, code: hcode[1]};
        else             nxt = '{fallback: 1'b1, code: '0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            cur <= '0;
        end else begin
            vld <= req;
            if (req) cur <= nxt;
        end
    end

    assign rsp_valid    = vld;
    assign rsp_rate     = cur.code;
    assign rsp_fallback = cur.fallback;
endmodule

// File: rtl/rsp_rate_sel_chk.sv
module rsp_rate_sel_chk
    import rsel_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic [3:0]  rx_rate,
    input logic [15:0] basic_tbl,
    input logic [15:0] mand_tbl,
    input logic        rsp_valid,
    input logic [3:0]  rsp_rate,
    input logic        rsp_fallback
);
    // R8
    vld_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> rsp_valid);

    // R8
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!rsp_valid && $stable(rsp_rate) && $stable(rsp_fallback)));

    // R6
    fb_code_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fallback) |-> (rsp_rate == 4'd0));

    // R4
    not_faster_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> (rsp_fallback ||
                 (code_rank(rsp_rate).ok &&
                  code_rank(rsp_rate).rank <= code_rank($past(rx_rate)).rank)));

    // R5
    from_table_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> (rsp_fallback ||
                 (($past(basic_tbl) | $past(mand_tbl)) & USED_MASK & (16'h1 << rsp_rate)) != 16'h0));

    // R10
    always @(posedge clk) begin
        if ($past(rst)) begin
            reset_state_chk: assert (!rsp_valid && rsp_rate == 4'd0 && !rsp_fallback);
        end
    end
endmodule

bind rsp_rate_sel rsp_rate_sel_chk u_chk (.*);

// File: tb/rsp_rate_sel_test.sv
module rsp_rate_sel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [3:0]  rx_rate = '0;
    logic [15:0] basic_tbl = '0;
    logic [15:0] mand_tbl = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_rate;
    logic        rsp_fallback;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    rsp_rate_sel uut (.*);

    // speed in units of 100 kb/s; 0 means no rate (R1, R2)
    function automatic int speed(int c);
        case (c)
            0: return 10;   1: return 20;   2: return 55;   3: return 110;
            8: return 60;   9: return 90;   10: return 120; 11: return 180;
            12: return 240; 13: return 360; 14: return 480; 15: return 540;
            default: return 0;
        endcase
    endfunction

    function automatic int best_of(logic [15:0] m, int lim);
        int b = -1;
        for (int c = 0; c < 16; c++)
            if (m[c] && speed(c) > 0 && speed(c) <= lim &&
                (b < 0 || speed(c) > speed(b))) b = c;
        return b;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one lookup against the bench model, result sampled after the edge
    task automatic lookup(string tag, logic [3:0] rx, logic [15:0] b, logic [15:0] m);
        int lim = speed(rx);
        int e;
        int ecode;
        bit efb;
        e = (lim == 0) ? -1 : best_of(b, lim);
        if (e < 0 && lim != 0) e = best_of(m, lim);
        efb   = (e < 0);
        ecode = efb ? 0 : e;
        @(negedge clk);
        req = 1'b1; rx_rate = rx; basic_tbl = b; mand_tbl = m;
        @(posedge clk); #1;
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " rate"}, 32'(rsp_rate), 32'(ecode));
        check({tag, " fallback"}, 32'(rsp_fallback), 32'(efb));
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check("R10 valid", 32'(rsp_valid), 32'd0);
        check("R10 rate", 32'(rsp_rate), 32'd0);
        check("R10 fallback", 32'(rsp_fallback), 32'd0);
    endtask

    task automatic t_basic;
        lookup("R1 R4 11M basic b", 4'd3, 16'h000F, 16'h0000);
        lookup("R2 R4 54M basic g", 4'd15, 16'hFF00, 16'h0000);
        lookup("R4 36M picks 24", 4'd13, 16'h1503, 16'h0000);
        lookup("R1 5.5 from 1,2,11", 4'd2, 16'h000B, 16'h0000);
    endtask

    task automatic t_rank;
        lookup("R3 11M picks 9M", 4'd3, 16'h0301, 16'h0000);
        lookup("R3 6M picks 5.5", 4'd8, 16'h0008 | 16'h0004, 16'h0000);
        lookup("R3 12M picks 11", 4'd10, 16'h0108, 16'h0000);
    endtask

    task automatic t_mand;
        lookup("R5 basic too fast", 4'd1, 16'h0008, 16'h0003);
        lookup("R5 basic wins", 4'd12, 16'h0100, 16'h1000);
    endtask

    task automatic t_fallback;
        lookup("R6 none qualifies", 4'd0, 16'hFF0E, 16'hFF0E);
        lookup("R6 empty tables", 4'd15, 16'h0000, 16'h0000);
    endtask

    task automatic t_unused;
        lookup("R7 dead bits only", 4'd15, 16'h00F0, 16'h00F0);
        lookup("R7 dead bits plus 1M", 4'd3, 16'h00F1, 16'h0000);
        lookup("R9 code 5", 4'd5, 16'hFFFF, 16'hFFFF);
        lookup("R9 code 7", 4'd7, 16'h0001, 16'h0001);
    endtask

    task automatic t_timing;
        lookup("R8 set", 4'd14, 16'h4000, 16'h0000);
        @(posedge clk); #1;
        check("R8 pulse low", 32'(rsp_valid), 32'd0);
        check("R8 rate held", 32'(rsp_rate), 32'd14);
        @(negedge clk);
        rx_rate = 4'd0; basic_tbl = 16'h0001;
        @(posedge clk); #1;
        check("R8 no req hold", 32'(rsp_rate), 32'd14);
    endtask

    task automatic t_sweep;
        logic [31:0] s = 32'h1234_5678;
        for (int i = 0; i < 300; i++) begin
            s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
            s = s * 32'd1103515245 + 32'd12345;
            lookup("R4 R5 sweep", s[3:0], s[19:4], s[31:16]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_basic();
        t_rank();
        t_mand();
        t_fallback();
        t_unused();
        t_timing();
        t_sweep();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule